// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block is the host-side engine that turns one operation request into the byte-wide bus traffic of an 8-bit multiplexed NAND flash device. A request names one of six operations: page read, page program, block erase, status read, identifier read or device reset. It also carries a 26-bit linear flash address, a spare-area select and a data byte count. The sequencer then walks the command, address and data cycles on the shared I/O lines. It drives chip enable, the command and address latch strobes, and the write and read strobes. When an operation leaves the device busy, it waits on the ready/busy line before it goes on.

The page half or spare region is chosen by a pointer command, not by an address cycle. Address bit 8 therefore only decides which pointer command opens a read or program, and it never appears on the bus. Write data enters through a valid/ready byte handshake. Read data leaves as one-cycle valid pulses. When the operation finishes, a one-cycle done pulse is raised, together with a pass/fail flag that comes from an automatic status read after a program or erase, and a timeout flag for a ready/busy line that does not respond.

Top module: `nand_cmd_seq`

## Requirements
- R1: A command byte is driven with the command latch high and the address latch low. An address byte is driven with the address latch high and the command latch low. A data byte is driven with both latches low. The two latches are never high together.
- R2: A read opens with pointer command 0x00 when address bit 8 is 0, 0x01 when bit 8 is 1, and 0x50 when the spare select is set. This is followed by four address cycles.
- R3: The address cycles carry, in this order: bits 7:0, bits 16:9, bits 24:17, then bit 25 in I/O bit 0 with zeros above it. Bit 8 is never sent.
- R4: A program sends the pointer command, then 0x80, four address cycles, the requested number of data bytes as taken from the write handshake, and then 0x10.
- R5: An erase sends 0x60, the last three address cycles of R3 (no column cycle), and then 0xD0.
- R6: A status read sends 0x70. An identifier read sends 0x90 and one address cycle of 0x00. A reset sends 0xFF. Status and identifier reads then read the requested number of bytes.
- R7: Every write-strobe and read-strobe low phase lasts T_LO clocks, and the following high phase lasts at least T_HI clocks. The I/O value does not change at a write-strobe rising edge.
- R8: After a read's last address cycle, 0x10, 0xD0 or 0xFF, the sequencer waits for ready/busy to go low and then high. Only then does it pulse the read strobe or finish.
- R9: If ready/busy does not make its expected transition within BUSY_TMO clocks, the operation finishes at once with the timeout flag set and no further bus cycles.
- R10: After a program or erase, the sequencer sends 0x70, reads one byte, and reports its bit 0 as the fail flag (1 = fail).
- R11: req_ready is high and chip enable is high only while idle. done is a single-cycle pulse, and req_ready returns the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_op | input | 3 | 0 read, 1 program, 2 erase, 3 status, 4 identifier, 5 reset |
| req_spare | input | 1 | Select the spare region for read or program |
| req_addr | input | 26 | Linear flash address |
| req_len | input | LEN_W | Data bytes to transfer |
| wdata | input | 8 | Program data byte |
| wdata_valid | input | 1 | Program data byte available |
| wdata_ready | output | 1 | Program data byte taken this cycle |
| rdata | output | 8 | Read data byte |
| rdata_valid | output | 1 | Read data byte valid this cycle |
| done | output | 1 | Operation finished (one cycle) |
| op_fail | output | 1 | Status bit 0 of the last program or erase |
| op_timeout | output | 1 | Ready/busy did not respond |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | I/O byte driven to the device |
| nand_io_oe | output | 1 | I/O output enable |
| nand_io_in | input | 8 | I/O byte from the device |
| nand_rb | input | 1 | Ready (1) / busy (0) |

## Verification
On every cycle, the assertions check that the two latch strobes are exclusive and that the write and read strobes never overlap. They also check that the I/O byte holds across each write-strobe rising edge, that chip enable is low whenever a strobe is low, that no strobe moves while ready/busy is awaited, and that done is a one-cycle pulse. The bench scenarios alone can show the following: the exact command, address and data byte streams for each operation; the conversion of bit 8 into a pointer command; strobe widths measured in clocks; the status-derived fail flag; and both timeout paths, with ready/busy stuck low and stuck high.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;
   typedef enum logic [2:0] {
      OP_READ   = 3'd0,
      OP_PROG   = 3'd1,
      OP_ERASE  = 3'd2,
      OP_STATUS = 3'd3,
      OP_READID = 3'd4,
      OP_RESET  = 3'd5
   } nand_op_e;

   typedef enum logic [1:0] {
      CYC_CMD  = 2'd0,
      CYC_ADDR = 2'd1,
      CYC_WR   = 2'd2,
      CYC_RD   = 2'd3
   } cyc_kind_e;

   localparam logic [7:0] K_PTR_LO   = 8'h00;
   localparam logic [7:0] K_PTR_HI   = 8'h01;
   localparam logic [7:0] K_PTR_SP   = 8'h50;
   localparam logic [7:0] K_PROG     = 8'h80;
   localparam logic [7:0] K_PROG_GO  = 8'h10;
   localparam logic [7:0] K_ERASE    = 8'h60;
   localparam logic [7:0] K_ERASE_GO = 8'hD0;
   localparam logic [7:0] K_STATUS   = 8'h70;
   localparam logic [7:0] K_IDENT    = 8'h90;
   localparam logic [7:0] K_RESET    = 8'hFF;
endpackage

// File: rtl/nand_addr_pick.sv
`timescale 1ns/1ps
module nand_addr_pick
   import nand_seq_pkg::*;
(
   input  logic [25:0] addr,
   input  logic        spare,
   input  logic [1:0]  idx,
   output logic [7:0]  addr_byte,
   output logic [7:0]  ptr_cmd
);
   // bit 8 never reaches the bus: it only chooses the pointer command
   always_comb begin
      case (idx)
         2'd0:    addr_byte = addr[7:0];
         2'd1:    addr_byte = addr[16:9];
         2'd2:    addr_byte = addr[24:17];
         default: addr_byte = {7'b0, addr[25]};
      endcase
   end

   assign ptr_cmd = spare ? K_PTR_SP : (addr[8] ? K_PTR_HI : K_PTR_LO);
endmodule

// File: rtl/nand_strobe.sv
`timescale 1ns/1ps
module nand_strobe
   import nand_seq_pkg::*;
#(
   parameter int T_LO = 3,
   parameter int T_HI = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  cyc_kind_e kind_in,
   input  logic [7:0] byte_in,
   input  logic [7:0] io_in,
   output logic      busy,
   output logic      step_done,
   output logic      we_n,
   output logic      re_n,
   output logic      cle,
   output logic      ale,
   output logic      io_oe,
   output logic [7:0] io_out,
   output logic [7:0] rd_byte
);
   localparam int MAXT = (T_LO > T_HI) ? T_LO : T_HI;
   localparam int CW   = $clog2(MAXT + 1);

   generate
      if (T_LO < 1 || T_HI < 1) begin : g_bad_timing
         $error("nand_strobe: T_LO and T_HI must be at least 1");
      end
   endgenerate

   typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} phase_e;
   phase_e    ph;
   logic [CW-1:0] cnt;
   cyc_kind_e kind;

   wire lo_end = (ph == PH_LO) && (cnt == CW'(T_LO - 1));
   wire hi_end = (ph == PH_HI) && (cnt == CW'(T_HI - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         cnt     <= '0;
         kind    <= CYC_CMD;
         io_out  <= '0;
         rd_byte <= '0;
      end else begin
         case (ph)
            PH_IDLE: if (start) begin
               ph     <= PH_LO;
               cnt    <= '0;
               kind   <= kind_in;
               io_out <= byte_in;
            end
            PH_LO: if (lo_end) begin
               ph  <= PH_HI;
               cnt <= '0;
               if (kind == CYC_RD) rd_byte <= io_in;
            end else cnt <= cnt + 1'b1;
            default: if (hi_end) ph <= PH_IDLE;
                     else cnt <= cnt + 1'b1;
         endcase
      end
   end

   assign busy      = (ph != PH_IDLE);
   assign step_done = hi_end;
   assign we_n      = !((ph == PH_LO) && (kind != CYC_RD));
   assign re_n      = !((ph == PH_LO) && (kind == CYC_RD));
   assign cle       = busy && (kind == CYC_CMD);
   assign ale       = busy && (kind == CYC_ADDR);
   assign io_oe     = busy && (kind != CYC_RD);

   p_latch_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));
   p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));
   p_io_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> $stable(io_out));
endmodule

// File: rtl/nand_rb_wait.sv
`timescale 1ns/1ps
module nand_rb_wait #(
   parameter int BUSY_TMO = 1024,
   parameter bit SYNC_RB  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic rb,
   output logic done,
   output logic tmo
);
   localparam int TW = $clog2(BUSY_TMO + 1);

   generate
      if (BUSY_TMO < 2) begin : g_bad_tmo
         $error("nand_rb_wait: BUSY_TMO must be at least 2");
      end
   endgenerate

   logic rb_s;
   generate
      if (SYNC_RB) begin : g_sync
         logic [1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= 2'b11;
            else        sync_q <= {sync_q[0], rb};
         end
         assign rb_s = sync_q[1];
      end else begin : g_direct
         assign rb_s = rb;
      end
   endgenerate

   typedef enum logic [1:0] {W_IDLE, W_LO, W_HI} wait_e;
   wait_e st;
   logic [TW-1:0] cnt;

   wire lo_ok  = (st == W_LO) && !rb_s;
   wire hi_ok  = (st == W_HI) && rb_s;
   wire expire = (st != W_IDLE) && !lo_ok && !hi_ok && (cnt == TW'(BUSY_TMO - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= W_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            W_IDLE: if (start) begin st <= W_LO; cnt <= '0; end
            W_LO: if (lo_ok) begin st <= W_HI; cnt <= '0; end
                  else if (expire) st <= W_IDLE;
                  else cnt <= cnt + 1'b1;
            default: if (hi_ok || expire) st <= W_IDLE;
                     else cnt <= cnt + 1'b1;
         endcase
      end
   end

   assign done = hi_ok || expire;
   assign tmo  = expire;

   p_ready_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !tmo) |-> rb_s);
endmodule

// File: rtl/nand_cmd_seq.sv
`timescale 1ns/1ps
module nand_cmd_seq
   import nand_seq_pkg::*;
#(
   parameter int T_LO     = 3,
   parameter int T_HI     = 2,
   parameter int BUSY_TMO = 4096,
   parameter int MAX_LEN  = 528,
   parameter bit SYNC_RB  = 1'b1,
   localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [2:0]       req_op,
   input  logic             req_spare,
   input  logic [25:0]      req_addr,
   input  logic [LEN_W-1:0] req_len,
   input  logic [7:0]       wdata,
   input  logic             wdata_valid,
   output logic             wdata_ready,
   output logic [7:0]       rdata,
   output logic             rdata_valid,
   output logic             done,
   output logic             op_fail,
   output logic             op_timeout,
   output logic             nand_ce_n,
   output logic             nand_cle,
   output logic             nand_ale,
   output logic             nand_we_n,
   output logic             nand_re_n,
   output logic [7:0]       nand_io_out,
   output logic             nand_io_oe,
   input  logic [7:0]       nand_io_in,
   input  logic             nand_rb
);
   generate
      if (MAX_LEN < 1) begin : g_bad_len
         $error("nand_cmd_seq: MAX_LEN must be at least 1");
      end
   endgenerate

   typedef enum logic [3:0] {
      S_IDLE, S_PTR, S_CMD1, S_ADDR, S_DATA, S_CMD2, S_WAIT, S_STCMD, S_STRD, S_DONE
   } seq_e;

   seq_e             st;
   nand_op_e         op_q;
   logic [25:0]      addr_q;
   logic             spare_q;
   logic [LEN_W-1:0] len_q, dcount;
   logic [1:0]       idx;
   logic             issued, wait_go, fail_q, tmo_q;

   logic       issue, stb_start, stb_busy, stb_done;
   cyc_kind_e  cyc_kind;
   logic [7:0] cyc_byte, addr_byte, ptr_cmd, rd_byte;
   logic       wt_done, wt_tmo;

   nand_addr_pick u_addr (
      .addr(addr_q), .spare(spare_q), .idx(idx), .addr_byte(addr_byte), .ptr_cmd(ptr_cmd)
   );

   nand_strobe #(.T_LO(T_LO), .T_HI(T_HI)) u_strobe (
      .clk(clk), .rst_n(rst_n), .start(stb_start), .kind_in(cyc_kind), .byte_in(cyc_byte),
      .io_in(nand_io_in), .busy(stb_busy), .step_done(stb_done), .we_n(nand_we_n),
      .re_n(nand_re_n), .cle(nand_cle), .ale(nand_ale), .io_oe(nand_io_oe),
      .io_out(nand_io_out), .rd_byte(rd_byte)
   );

   nand_rb_wait #(.BUSY_TMO(BUSY_TMO), .SYNC_RB(SYNC_RB)) u_wait (
      .clk(clk), .rst_n(rst_n), .start(wait_go), .rb(nand_rb), .done(wt_done), .tmo(wt_tmo)
   );

   // byte for the bus cycle of the current state
   always_comb begin
      issue    = 1'b1;
      cyc_kind = CYC_CMD;
      cyc_byte = 8'h00;
      case (st)
         S_PTR:  cyc_byte = ptr_cmd;
         S_CMD1: case (op_q)
                    OP_PROG:   cyc_byte = K_PROG;
                    OP_ERASE:  cyc_byte = K_ERASE;
                    OP_STATUS: cyc_byte = K_STATUS;
                    OP_READID: cyc_byte = K_IDENT;
                    default:   cyc_byte = K_RESET;
                 endcase
         S_ADDR: begin
            cyc_kind = CYC_ADDR;
            cyc_byte = (op_q == OP_READID) ? 8'h00 : addr_byte;
         end
         S_DATA: if (op_q == OP_PROG) begin
                    cyc_kind = CYC_WR;
                    cyc_byte = wdata;
                 end else cyc_kind = CYC_RD;
         S_CMD2:  cyc_byte = (op_q == OP_PROG) ? K_PROG_GO : K_ERASE_GO;
         S_STCMD: cyc_byte = K_STATUS;
         S_STRD:  cyc_kind = CYC_RD;
         default: issue = 1'b0;
      endcase
   end

   assign stb_start = issue && !issued && !stb_busy && ((cyc_kind != CYC_WR) || wdata_valid);

   wire  addr_last = (op_q == OP_READID) || (idx == 2'd3);
   wire  data_last = (dcount == len_q - 1'b1);
   seq_e data_entry;
   assign data_entry = (len_q != '0) ? S_DATA : ((op_q == OP_PROG) ? S_CMD2 : S_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; op_q <= OP_RESET; addr_q <= '0; spare_q <= 1'b0; len_q <= '0;
         dcount <= '0; idx <= '0; issued <= 1'b0; wait_go <= 1'b0;
         fail_q <= 1'b0; tmo_q <= 1'b0;
      end else begin
         wait_go <= 1'b0;
         if (stb_start)     issued <= 1'b1;
         else if (stb_done) issued <= 1'b0;
         case (st)
            S_IDLE: if (req_valid) begin
               op_q <= nand_op_e'(req_op); addr_q <= req_addr; spare_q <= req_spare;
               len_q <= req_len; dcount <= '0; idx <= '0; fail_q <= 1'b0; tmo_q <= 1'b0;
               case (req_op)
                  3'd0, 3'd1:             st <= S_PTR;
                  3'd2, 3'd3, 3'd4, 3'd5: st <= S_CMD1;
                  default:                st <= S_DONE;
               endcase
            end
            S_PTR: if (stb_done) st <= (op_q == OP_PROG) ? S_CMD1 : S_ADDR;
            S_CMD1: if (stb_done) case (op_q)
               OP_PROG, OP_READID: st <= S_ADDR;
               OP_ERASE:  begin st <= S_ADDR; idx <= 2'd1; end
               OP_STATUS: st <= data_entry;
               default:   begin st <= S_WAIT; wait_go <= 1'b1; end
            endcase
            S_ADDR: if (stb_done) begin
               if (addr_last) case (op_q)
                  OP_READ:            begin st <= S_WAIT; wait_go <= 1'b1; end
                  OP_PROG, OP_READID: st <= data_entry;
                  default:            st <= S_CMD2;
               endcase else idx <= idx + 1'b1;
            end
            S_DATA: if (stb_done) begin
               dcount <= dcount + 1'b1;
               if (data_last) st <= (op_q == OP_PROG) ? S_CMD2 : S_DONE;
            end
            S_CMD2: if (stb_done) begin st <= S_WAIT; wait_go <= 1'b1; end
            S_WAIT: if (wt_done) begin
               if (wt_tmo) begin tmo_q <= 1'b1; st <= S_DONE; end
               else case (op_q)
                  OP_READ:            st <= data_entry;
                  OP_PROG, OP_ERASE:  st <= S_STCMD;
                  default:            st <= S_DONE;
               endcase
            end
            S_STCMD: if (stb_done) st <= S_STRD;
            S_STRD:  if (stb_done) begin fail_q <= rd_byte[0]; st <= S_DONE; end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign req_ready   = (st == S_IDLE);
   assign nand_ce_n   = (st == S_IDLE);
   assign done        = (st == S_DONE);
   assign op_fail     = fail_q;
   assign op_timeout  = tmo_q;
   assign rdata       = rd_byte;
   assign rdata_valid = stb_done && (st == S_DATA) && (op_q != OP_PROG);
   assign wdata_ready = stb_start && (cyc_kind == CYC_WR);

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_ce_during_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
   p_quiet_in_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WAIT) |-> (nand_we_n && nand_re_n));
   p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/nand_cmd_seq_bench.sv
`timescale 1ns/1ps
module nand_cmd_seq_bench;
   localparam int T_LO = 2, T_HI = 2, TMO = 200, MAX_LEN = 528;
   localparam int LEN_W = $clog2(MAX_LEN + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic req_valid = 1'b0, req_spare = 1'b0, wdata_valid = 1'b0;
   logic [2:0] req_op = '0;
   logic [25:0] req_addr = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic [7:0] wdata, rdata, nand_io_out, nand_io_in;
   logic req_ready, wdata_ready, rdata_valid, done, op_fail, op_timeout;
   logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
   logic nand_rb = 1'b1;

   nand_cmd_seq #(.T_LO(T_LO), .T_HI(T_HI), .BUSY_TMO(TMO), .MAX_LEN(MAX_LEN)) u_nand_cmd_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_spare(req_spare), .req_addr(req_addr), .req_len(req_len), .wdata(wdata),
      .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .rdata(rdata),
      .rdata_valid(rdata_valid), .done(done), .op_fail(op_fail), .op_timeout(op_timeout),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
      .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
      .nand_io_in(nand_io_in), .nand_rb(nand_rb)
   );

   int errors = 0, checks = 0;
   task automatic check(input string req, input string what, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp_v);
      end
   endtask

   // ---------------- device model ----------------
   int log_q [64];
   int log_n = 0, dcnt = 0, acnt = 0, rd_idx = 0, busy_trig = 0, busy_seen = 0, busy_left = 0;
   int rb_mode = 0, cyc = 0, we_fall = 0, re_fall = 0;
   int bad_w = 0, bad_io = 0, bad_both = 0, bad_re = 0;
   logic [7:0] last_cmd = 8'hFF, stat_val = 8'h00, io_at_fall = 8'h00;

   assign wdata = 8'h30 + dcnt[7:0];
   assign nand_io_in = (last_cmd == 8'h70) ? stat_val :
                       (((last_cmd == 8'h90) ? 8'hEC : 8'hA0) + rd_idx[7:0]);

   always @(negedge clk) cyc++;

   always @(negedge nand_we_n) if (rst_n) begin
      we_fall = cyc; io_at_fall = nand_io_out;
   end
   always @(posedge nand_we_n) if (rst_n) begin
      if (cyc - we_fall != T_LO) bad_w++;
      if (nand_io_out != io_at_fall) bad_io++;
      if (nand_cle && nand_ale) bad_both++;
      if (log_n < 64) log_q[log_n] = (nand_cle ? 1 : nand_ale ? 2 : 3) * 256 + int'(nand_io_out);
      log_n++;
      if (nand_cle) begin
         last_cmd = nand_io_out; acnt = 0; rd_idx = 0;
         if (nand_io_out == 8'h10 || nand_io_out == 8'hD0 || nand_io_out == 8'hFF) busy_trig++;
      end else if (nand_ale) begin
         acnt++;
         if (acnt == 4 && (last_cmd == 8'h00 || last_cmd == 8'h01 || last_cmd == 8'h50)) busy_trig++;
      end else dcnt++;
   end
   always @(negedge nand_re_n) if (rst_n) begin
      re_fall = cyc;
      if (!nand_rb) bad_re++;
   end
   always @(posedge nand_re_n) if (rst_n) begin
      if (cyc - re_fall != T_LO) bad_w++;
      rd_idx++;
   end
   always @(negedge clk) begin
      if (busy_trig != busy_seen) begin busy_seen = busy_trig; busy_left = 12; end
      if (rb_mode == 1) nand_rb = 1'b0;
      else if (rb_mode == 2) nand_rb = 1'b1;
      else if (busy_left > 0) begin nand_rb = 1'b0; busy_left--; end
      else nand_rb = 1'b1;
   end

   int rbuf [16];
   int rcount = 0;
   always @(negedge clk) if (rdata_valid) begin
      if (rcount < 16) rbuf[rcount] = int'(rdata);
      rcount++;
   end

   // ---------------- expected streams ----------------
   int exp_q [64];
   int exp_n;
   task automatic push(input int k, input int b);
      exp_q[exp_n] = k * 256 + b; exp_n++;
   endtask
   task automatic push_addr(input logic [25:0] a, input int first);
      for (int i = first; i < 4; i++)
         case (i)
            0: push(2, int'(a[7:0]));
            1: push(2, int'(a[16:9]));
            2: push(2, int'(a[24:17]));
            default: push(2, int'(a[25]));
         endcase
   endtask
   task automatic build_exp(input int op, input logic sp, input logic [25:0] a, input int len, input bit tmo);
      int ptr = sp ? 'h50 : (a[8] ? 'h01 : 'h00);
      exp_n = 0;
      case (op)
         0: begin push(1, ptr); push_addr(a, 0); end
         1: begin push(1, ptr); push(1, 'h80); push_addr(a, 0);
                  for (int i = 0; i < len; i++) push(3, 'h30 + i);
                  push(1, 'h10); if (!tmo) push(1, 'h70); end
         2: begin push(1, 'h60); push_addr(a, 1); push(1, 'hD0); if (!tmo) push(1, 'h70); end
         3: push(1, 'h70);
         4: begin push(1, 'h90); push(2, 0); end
         default: push(1, 'hFF);
      endcase
   endtask

   task automatic cmp_stream(input string tag);
      check(tag, "bus cycle count", log_n, exp_n);
      for (int i = 0; i < exp_n && i < log_n; i++)
         check((exp_q[i] / 256 == 2) ? "R3" : tag, $sformatf("bus cycle %0d", i), log_q[i], exp_q[i]);
   endtask

   int got_fail, got_tmo, gap_done;
   task automatic run_op(input int op, input logic sp, input logic [25:0] a, input int len);
      log_n = 0; dcnt = 0; rcount = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = 3'(op); req_spare = sp; req_addr = a; req_len = LEN_W'(len);
      wdata_valid = (op == 1);
      @(negedge clk);
      req_valid = 1'b0;
      while (!done) @(negedge clk);
      got_fail = int'(op_fail); got_tmo = int'(op_timeout);
      @(negedge clk);
      gap_done = int'(done);
      wdata_valid = 1'b0;
   endtask

   typedef struct packed {
      logic [2:0]  op;
      logic        sp;
      logic [25:0] a;
      logic [7:0]  len;
      logic [7:0]  stat;
      logic        fail;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{3'd0, 1'b0, 26'h2D5A0C3, 8'd4, 8'hC0, 1'b0},
      '{3'd0, 1'b0, 26'h156B1E7, 8'd3, 8'hC0, 1'b0},
      '{3'd0, 1'b1, 26'h0000010, 8'd2, 8'hC0, 1'b0},
      '{3'd1, 1'b0, 26'h3FFE0FF, 8'd3, 8'hC0, 1'b0},
      '{3'd1, 1'b0, 26'h1A2B3C4, 8'd2, 8'hC1, 1'b1},
      '{3'd2, 1'b0, 26'h2468ACE, 8'd0, 8'hC0, 1'b0},
      '{3'd2, 1'b0, 26'h3FFFFFF, 8'd0, 8'hE1, 1'b1},
      '{3'd3, 1'b0, 26'h0000000, 8'd1, 8'hE0, 1'b0},
      '{3'd4, 1'b0, 26'h0000000, 8'd2, 8'hC0, 1'b0},
      '{3'd5, 1'b0, 26'h0000000, 8'd0, 8'hC0, 1'b0}
   };

   bit finished = 1'b0;
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // reset state (R11, R1)
      check("R11", "req_ready in reset", int'(req_ready), 1);
      check("R11", "ce_n in reset", int'(nand_ce_n), 1);
      check("R11", "done in reset", int'(done), 0);
      check("R1", "latches in reset", int'({nand_cle, nand_ale}), 0);
      check("R7", "strobes in reset", int'({nand_we_n, nand_re_n}), 3);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      foreach (VECS[i]) begin
         vec_t v = VECS[i];
         string tag;
         int op = int'(v.op);
         tag = (op == 0) ? "R2" : (op == 1) ? "R4" : (op == 2) ? "R5" : "R6";
         stat_val = v.stat;
         run_op(op, v.sp, v.a, int'(v.len));
         build_exp(op, v.sp, v.a, int'(v.len), 1'b0);
         cmp_stream(tag);
         if (op == 0 || op == 3 || op == 4) begin
            check("R8", "read byte count", rcount, int'(v.len));
            for (int k = 0; k < int'(v.len) && k < rcount; k++)
               check("R8", $sformatf("read byte %0d", k), rbuf[k],
                     (op == 3) ? int'(v.stat) : ((op == 4) ? 'hEC : 'hA0) + k);
         end
         if (op == 1 || op == 2) check("R10", "fail flag", got_fail, int'(v.fail));
         check("R9", "timeout flag clear", got_tmo, 0);
         check("R11", "done single cycle", gap_done, 0);
         check("R11", "ready after done", int'({req_ready, nand_ce_n}), 3);
      end

      // busy stuck low during erase
      rb_mode = 1;
      run_op(2, 1'b0, 26'h0ABCDEF, 0);
      build_exp(2, 1'b0, 26'h0ABCDEF, 0, 1'b1);
      check("R9", "timeout on stuck busy", got_tmo, 1);
      cmp_stream("R9");
      // ready never drops after read address
      rb_mode = 2;
      run_op(0, 1'b0, 26'h1111111, 3);
      build_exp(0, 1'b0, 26'h1111111, 3, 1'b1);
      check("R9", "timeout on missing busy", got_tmo, 1);
      check("R9", "no read data after timeout", rcount, 0);
      cmp_stream("R9");
      rb_mode = 0;
      repeat (20) @(negedge clk);
      // program with zero length: no data cycles
      stat_val = 8'hC0;
      run_op(1, 1'b1, 26'h0000007, 0);
      build_exp(1, 1'b1, 26'h0000007, 0, 1'b0);
      cmp_stream("R4");

      check("R7", "strobe low width mismatches", bad_w, 0);
      check("R7", "io change at write rise", bad_io, 0);
      check("R1", "both latches high", bad_both, 0);
      check("R8", "read strobe while busy", bad_re, 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule